// File: doc/BRIEF.md
# Serial Receive Channel with Error Flags

This block takes in asynchronous serial characters on a single line and presents each finished byte in a holding register that software reads. A character is made up of a low start bit, eight data bits sent least significant bit first, a parity bit and one high stop bit. The bit timing comes from a tick that pulses sixteen times per bit period; the tick is produced elsewhere. The line is brought into the clock domain by two flops. Bit timing is locked to the falling edge of each start bit.

Every finished character goes through three checks: parity against the selected mode, a high stop bit, and whether the previous byte has been read. A failed check raises a sticky flag. Software clears each flag with its own strobe. The buffer-full flag is cleared by the read strobe and by nothing else. A receive interrupt pulses when each character ends. An error interrupt pulses when a check fails, and it also pulses for any character that ends while an older flag is still set.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, rx_data is 0x00 and buf_full, err_par, err_frm, err_ovr, irq_rx and irq_err are all 0.
- R2: While rx_en is 0 the receiver stays idle and ignores rx_i, so a whole character sent in that time changes no output.
- R3: Data bits arrive LSB first and are sampled at tick 8 of their 16 ticks. A character that ends with buf_full clear loads its byte into rx_data. rx_data changes only when a character ends.
- R4: A low pulse that is back high at the mid-start sample (8 ticks after the falling edge is seen) counts as a false start, and the receiver returns to idle with no output change.
- R5: When par_odd is 0 the data bits plus the parity bit must hold an even number of ones, and when par_odd is 1 an odd number. A mismatch sets err_par.
- R6: A stop bit sampled as 0 sets err_frm. A start bit sampled low is a condition for reception, so the start-bit side of the check always passes.
- R7: When a character ends, buf_full is set and irq_rx is high for exactly one clock.
- R8: A character that ends while buf_full is still set sets err_ovr. rx_data keeps the unread byte and the new byte is dropped.
- R9: irq_err pulses for one clock when a character ends with a failed check, or when any of err_par, err_frm, err_ovr was already set.
- R10: err_par, err_frm and err_ovr stay set until a one-clock pulse on clr_par, clr_frm or clr_ovr clears the matching flag.
- R11: A one-clock pulse on rd_strobe clears buf_full. Nothing else clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| par_odd | input | 1 | Parity mode: 0 even, 1 odd |
| tick16 | input | 1 | One-clock pulse, 16 per bit period |
| rd_strobe | input | 1 | Read of the data register, clears buf_full |
| clr_par | input | 1 | Clears err_par |
| clr_frm | input | 1 | Clears err_frm |
| clr_ovr | input | 1 | Clears err_ovr |
| rx_data | output | 8 | Last accepted byte |
| buf_full | output | 1 | Unread byte present |
| err_par | output | 1 | Sticky parity error |
| err_frm | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun error |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
The bench sends the bytes 0xA5, 0x01, 0x55 and 0x80 with correct parity in both parity modes. These patterns would reveal a reversed bit order or an inverted parity sense. A byte with a wrong parity bit, a byte with a low stop bit, and two bytes sent back to back without a read trigger one error each. This shows which flag belongs to which check, and shows that an overrun keeps the older byte. A clean byte sent while a flag is still set must raise the error interrupt again. A short low glitch and a full character sent with reception disabled must both leave every output unchanged.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic          rx_en,
  input  logic          par_odd,
  input  logic          tick16,
  input  logic          rd_strobe,
  input  logic          clr_par,
  input  logic          clr_frm,
  input  logic          clr_ovr,
  output logic [DW-1:0] rx_data,
  output logic          buf_full,
  output logic          err_par,
  output logic          err_frm,
  output logic          err_ovr,
  output logic          irq_rx,
  output logic          irq_err
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DW + 1);
  localparam logic [CW-1:0] HALF = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t            state;
  logic [1:0]     sync;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bitn;
  logic [DW-1:0]  shreg;
  logic           par_bit;

  wire rx_s    = sync[1];
  wire at_last = tick16 && cnt == LAST;
  wire done    = rx_en && state == S_STOP && at_last;
  wire par_bad = ((^shreg) ^ par_bit) != par_odd;
  wire frm_bad = !rx_s;
  wire ovr_bad = buf_full;
  wire any_err = par_bad | frm_bad | ovr_bad | err_par | err_frm | err_ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
    end else if (!rx_en) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (tick16) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (!rx_s) state <= S_START;
        end
        S_START: if (cnt == HALF) begin
          cnt   <= '0;
          bitn  <= '0;
          state <= rx_s ? S_IDLE : S_DATA;
        end
        S_DATA: if (cnt == LAST) begin
          shreg <= {rx_s, shreg[DW-1:1]};
          bitn  <= bitn + 1'b1;
          if (bitn == BW'(DW - 1)) state <= S_PAR;
        end
        S_PAR: if (cnt == LAST) begin
          par_bit <= rx_s;
          state   <= S_STOP;
        end
        S_STOP: if (cnt == LAST) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      buf_full <= 1'b0;
      err_par  <= 1'b0;
      err_frm  <= 1'b0;
      err_ovr  <= 1'b0;
      irq_rx   <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      if (done && !buf_full) rx_data <= shreg;
      buf_full <= done | (buf_full & ~rd_strobe);
      err_par  <= (done & par_bad) | (err_par & ~clr_par);
      err_frm  <= (done & frm_bad) | (err_frm & ~clr_frm);
      err_ovr  <= (done & ovr_bad) | (err_ovr & ~clr_ovr);
      irq_rx   <= done;
      irq_err  <= done & any_err;
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !irq_rx); // R2
  AST_DATA_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data != $past(rx_data)) |-> irq_rx); // R3
  AST_IRQ_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx); // R7
  AST_IRQ_RX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> buf_full); // R7
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovr) |-> $stable(rx_data)); // R8
  AST_IRQ_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> irq_rx); // R9
  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_par && !clr_par) |=> err_par); // R10
  AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frm && !clr_frm) |=> err_frm); // R10
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovr && !clr_ovr) |=> err_ovr); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (!buf_full || irq_rx)); // R11
endmodule

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, rx_en = 1'b1, par_odd = 1'b0, tick16 = 1'b0;
  logic rd = 1'b0, c_par = 1'b0, c_frm = 1'b0, c_ovr = 1'b0;
  logic [7:0] rx_data;
  logic buf_full, err_par, err_frm, err_ovr, irq_rx, irq_err;

  int checks = 0, errors = 0, n = 0, irq_err_cnt = 0;

  typedef struct { int e; logic [7:0] d; logic p; logic s; } ev_t;
  ev_t q[$];

  logic [7:0] m_data = 8'h00;
  logic m_full = 0, m_par = 0, m_frm = 0, m_ovr = 0, m_irx = 0, m_ierr = 0;

  uart_rx_status i_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .rx_en(rx_en), .par_odd(par_odd),
    .tick16(tick16), .rd_strobe(rd), .clr_par(c_par), .clr_frm(c_frm),
    .clr_ovr(c_ovr), .rx_data(rx_data), .buf_full(buf_full), .err_par(err_par),
    .err_frm(err_frm), .err_ovr(err_ovr), .irq_rx(irq_rx), .irq_err(irq_err));

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at edge %0d", req, act, exp, n);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_full = 0; m_par = 0; m_frm = 0; m_ovr = 0; m_irx = 0; m_ierr = 0;
    end else begin
      logic done, pb, fb, ob;
      done = 0; pb = 0; fb = 0; ob = 0;
      if (q.size() > 0 && q[0].e == n) begin
        ev_t ev;
        ev = q.pop_front();
        done = 1;
        pb = (($countones({ev.d, ev.p}) % 2) == 1) != par_odd;
        fb = !ev.s;
        ob = m_full;
        if (!m_full) m_data = ev.d;
      end
      m_irx  = done;
      m_ierr = done && (pb || fb || ob || m_par || m_frm || m_ovr);
      m_par  = (done && pb) || (m_par && !c_par);
      m_frm  = (done && fb) || (m_frm && !c_frm);
      m_ovr  = (done && ob) || (m_ovr && !c_ovr);
      m_full = done || (m_full && !rd);
    end
  end

  always @(negedge clk) begin
    n++;
    if (rst_n) begin
      check("R3 rx_data", rx_data, m_data);
      check("R7/R11 buf_full", buf_full, m_full);
      check("R5 err_par", err_par, m_par);
      check("R6 err_frm", err_frm, m_frm);
      check("R8 err_ovr", err_ovr, m_ovr);
      check("R7 irq_rx", irq_rx, m_irx);
      check("R9 irq_err", irq_err, m_ierr);
      if (irq_err) irq_err_cnt++;
    end
    tick16 = (n % 4 == 0);
  end

  task automatic wait_clk(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
    #1;
  endtask

  task automatic send(logic [7:0] d, logic p, logic s, bit expect_rx);
    ev_t ev;
    @(negedge clk); #1;
    while (n % 4 != 0) begin @(negedge clk); #1; end
    if (expect_rx) begin
      ev.e = n + 676; ev.d = d; ev.p = p; ev.s = s;
      q.push_back(ev);
    end
    rx = 1'b0; wait_clk(64);
    for (int b = 0; b < 8; b++) begin rx = d[b]; wait_clk(64); end
    rx = p; wait_clk(64);
    rx = s; wait_clk(64);
    rx = 1'b1; wait_clk(64);
  endtask

  function automatic logic good_par(logic [7:0] d);
    return (^d) ^ par_odd;
  endfunction

  task automatic pulse(ref logic sig);
    @(negedge clk); #1; sig = 1'b1;
    @(negedge clk); #1; sig = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
    check("R1 reset data", rx_data, 0);
    check("R1 reset flags", {buf_full, err_par, err_frm, err_ovr, irq_rx, irq_err}, 0);

    send(8'hA5, good_par(8'hA5), 1'b1, 1);
    check("R3 byte A5", rx_data, 8'hA5);
    check("R7 full", buf_full, 1);
    pulse(rd); wait_clk(2);
    check("R11 read clears", buf_full, 0);

    par_odd = 1'b1;
    send(8'h01, good_par(8'h01), 1'b1, 1);
    check("R3 byte 01", rx_data, 8'h01);
    check("R5 odd ok", err_par, 0);
    pulse(rd);

    base = irq_err_cnt;
    send(8'h3C, ~good_par(8'h3C), 1'b1, 1);
    check("R5 bad parity", err_par, 1);
    check("R9 irq on error", irq_err_cnt - base, 1);
    pulse(rd);
    send(8'h55, good_par(8'h55), 1'b1, 1);
    check("R9 irq while flag set", irq_err_cnt - base, 2);
    check("R10 flag held", err_par, 1);
    pulse(c_par); wait_clk(2);
    check("R10 cleared", err_par, 0);
    pulse(rd);

    par_odd = 1'b0;
    send(8'h0F, good_par(8'h0F), 1'b0, 1);
    wait_clk(100);
    check("R6 framing", err_frm, 1);
    check("R6 data still loaded", rx_data, 8'h0F);
    pulse(c_frm); pulse(rd); wait_clk(2);
    check("R10 frm cleared", err_frm, 0);

    send(8'h11, good_par(8'h11), 1'b1, 1);
    send(8'h22, good_par(8'h22), 1'b1, 1);
    check("R8 overrun", err_ovr, 1);
    check("R8 data kept", rx_data, 8'h11);
    pulse(rd); wait_clk(2);
    check("R11 read after overrun", buf_full, 0);
    pulse(c_ovr); wait_clk(2);
    check("R10 ovr cleared", err_ovr, 0);

    @(negedge clk); #1;
    while (n % 4 != 0) begin @(negedge clk); #1; end
    rx = 1'b0; wait_clk(16); rx = 1'b1; wait_clk(200);
    check("R4 false start ignored", {buf_full, rx_data}, {1'b0, 8'h11});
    send(8'h80, good_par(8'h80), 1'b1, 1);
    check("R4 receives after glitch", rx_data, 8'h80);
    pulse(rd);

    rx_en = 1'b0;
    send(8'h7E, good_par(8'h7E), 1'b1, 0);
    check("R2 disabled ignored", {buf_full, rx_data}, {1'b0, 8'h80});
    rx_en = 1'b1; wait_clk(8);
    send(8'hC3, good_par(8'hC3), 1'b1, 1);
    check("R2 enabled again", rx_data, 8'hC3);
    check("R5 no parity error", err_par, 0);
    wait_clk(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule